// File: doc/BRIEF.md
# Auxiliary I/O Port Supply Sequencer

This block runs the supply of a set of auxiliary digital I/O ports (two by default). For each port the host asks for a supply level: off, 1.8 V, 2.5 V or 3.3 V. The block then drives a port enable and two level-select enables in a fixed order. First every enable is dropped. Next the level selects are applied. Last the port enable is raised and the block waits for the port's power-good input. If power-good does not come within one second, counted in clock cycles, the block raises a sticky timeout flag.

Each port also has an external-power enable that the host sets or clears. The port's active-low fault line is synchronised and watched for a falling edge. On such an edge the block switches the external supply off and records a fault. The fault stays recorded until the host writes the external-power enable again. The host sees a per-port busy flag while a sequence is running. It also sees a two-bit external-power state.

Top module: `dio_power_seq`

## Requirements
- R1: The two-bit level code on `lvl_req` is 0 = off, 1 = 1.8 V, 2 = 2.5 V, 3 = 3.3 V. Once a sequence is complete, the triple (`port_en`, `sel_2v5`, `sel_3v3`) is 000, 100, 110 or 101 respectively, and the two selects are never high together.
- R2: In the clock cycle after a level write, all three enables of that port are low and `busy` is high.
- R3: One cycle after the clear, the port's selects take the new level's values while `port_en` stays low. `port_en` rises only after the selects have been stable for a cycle. `port_en` never rises for the off level.
- R4: For a level other than off, `busy` stays high until the power-good input has passed a two-flop synchroniser and been seen high. The sequence for off completes without waiting.
- R5: If power-good is not seen within CLK_HZ cycles of `port_en` going high, `pg_timeout` is set, `busy` drops and the enables keep the requested level. The flag stays set until the next level write to that port.
- R6: A falling edge on a port's `fault_n` (high to low) clears that port's `ext_en` and records a fault, three clock edges after the input falls.
- R7: A host write on `ext_wr` loads `ext_en` from `ext_val` on the next edge and clears the recorded fault. If the write and a fault edge fall on the same cycle, the fault wins.
- R8: `ext_state` per port is 2 when a fault is recorded, otherwise 1 when `ext_en` is high, otherwise 0.
- R9: During reset all enables are low, `ext_en` is low and no fault is recorded. After reset every port sequences to 3.3 V on its own.
- R10: A level write that arrives while a sequence is running restarts it from the clear step, with a fresh timeout count.
- R11: Ports are independent: a request, timeout or fault on one port leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_wr | input | NPORT | Per-port level write strobe |
| lvl_req | input | 2*NPORT | Per-port level code, two bits each |
| ext_wr | input | NPORT | Per-port external-power write strobe |
| ext_val | input | NPORT | Value written to the external-power enable |
| pgood | input | NPORT | Asynchronous power-good input per port |
| fault_n | input | NPORT | Asynchronous active-low fault line per port |
| port_en | output | NPORT | Port supply enable |
| sel_2v5 | output | NPORT | 2.5 V level select |
| sel_3v3 | output | NPORT | 3.3 V level select |
| ext_en | output | NPORT | External-power enable |
| busy | output | NPORT | Sequence in progress |
| pg_timeout | output | NPORT | Sticky power-good timeout |
| ext_state | output | 2*NPORT | External-power state: 0 off, 1 on, 2 fault |

## Verification
The assertions check the ordering rules on every cycle:
- no port enable rises before its selects are stable;
- the enable never rises for the off level;
- the selects are never high together;
- the clear always follows a level write;
- a timeout only ends a running sequence with power-good absent;
- a detected fault edge always removes external power.

Only the bench scenarios can show the following, because they depend on chosen inputs and exact cycle counts:
- the exact encoding per level;
- the timeout firing at precisely CLK_HZ cycles;
- the restart on a mid-sequence request;
- the three-edge fault latency;
- the clearing of the fault by a host write;
- the independence of the two ports.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        LV_OFF = 2'd0,
        LV_1V8 = 2'd1,
        LV_2V5 = 2'd2,
        LV_3V3 = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        SQ_CLEAR = 2'd0,
        SQ_SEL   = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_DONE  = 2'd3
    } seq_e;

    typedef enum logic [1:0] {
        XS_OFF   = 2'd0,
        XS_ON    = 2'd1,
        XS_FAULT = 2'd2
    } xstate_e;

    typedef struct packed {
        logic en;
        logic s25;
        logic s33;
    } rail_t;

    // Select pattern for a level; the enable bit is filled in by the sequencer.
    function automatic rail_t rail_of(lvl_e l);
        rail_t r;
        r.en  = (l != LV_OFF);
        r.s25 = (l == LV_2V5);
        r.s33 = (l == LV_3V3);
        return r;
    endfunction

endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
    parameter int W       = 1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= {W{RST_VAL}};
            q  <= {W{RST_VAL}};
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/dps_seq.sv
module dps_seq
    import dps_pkg::*;
#(
    parameter int TMO_CYC = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_wr,
    input  logic [1:0] lvl_req,
    input  logic       pg_s,
    output rail_t      rail,
    output logic       busy,
    output logic       tmo
);
    localparam int CW = $clog2(TMO_CYC + 1);

    seq_e            st;
    lvl_e            lvl;
    logic [CW-1:0]   cnt;
    rail_t           tgt;

    assign tgt = rail_of(lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_CLEAR;
            lvl <= LV_3V3;
            cnt <= '0;
            tmo <= 1'b0;
        end else if (lvl_wr) begin
            st  <= SQ_CLEAR;
            lvl <= lvl_e'(lvl_req);
            cnt <= '0;
            tmo <= 1'b0;
        end else begin
            unique case (st)
                SQ_CLEAR: begin
                    st  <= SQ_SEL;
                    cnt <= '0;
                end
                SQ_SEL:   st <= (lvl == LV_OFF) ? SQ_DONE : SQ_WAIT;
                SQ_WAIT: begin
                    if (pg_s) begin
                        st <= SQ_DONE;
                    end else if (cnt == CW'(TMO_CYC - 1)) begin
                        st  <= SQ_DONE;
                        tmo <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default:  st <= SQ_DONE;
            endcase
        end
    end

    always_comb begin
        rail = '0;
        unique case (st)
            SQ_CLEAR: rail = '0;
            SQ_SEL:   begin rail = tgt; rail.en = 1'b0; end
            default:  rail = tgt;
        endcase
    end

    assign busy = (st != SQ_DONE);

    a_r1_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({rail.s25, rail.s33}) <= 1);

    a_r2_clear_after_write: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> (rail == '0) && busy);

    a_r3_sel_before_en: assert property (@(posedge clk) disable iff (rst)
        $rose(rail.en) |-> $stable({rail.s25, rail.s33}));

    a_r3_off_no_en: assert property (@(posedge clk) disable iff (rst)
        rail.en |-> (lvl != LV_OFF));

    a_r5_tmo_from_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo) |-> !busy && $past(busy) && !$past(pg_s));
endmodule

// File: rtl/dps_extpwr.sv
module dps_extpwr
    import dps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flt_s,
    input  logic       ext_wr,
    input  logic       ext_val,
    output logic       ext_en,
    output logic [1:0] state
);
    logic flt_prev;
    logic flt_hit;
    logic flt_set;

    assign flt_hit = flt_prev & ~flt_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_prev <= 1'b1;
            ext_en   <= 1'b0;
            flt_set  <= 1'b0;
        end else begin
            flt_prev <= flt_s;
            if (flt_hit) begin
                ext_en  <= 1'b0;
                flt_set <= 1'b1;
            end else if (ext_wr) begin
                ext_en  <= ext_val;
                flt_set <= 1'b0;
            end
        end
    end

    always_comb begin
        if (flt_set)     state = XS_FAULT;
        else if (ext_en) state = XS_ON;
        else             state = XS_OFF;
    end

    a_r6_fault_kills_power: assert property (@(posedge clk) disable iff (rst)
        flt_hit |=> !ext_en && (state == XS_FAULT));

    a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
        (ext_wr && !flt_hit) |=> (ext_en == $past(ext_val)) && (state != XS_FAULT));
endmodule

// File: rtl/dio_power_seq.sv
module dio_power_seq
    import dps_pkg::*;
#(
    parameter int NPORT  = 2,
    parameter int CLK_HZ = 100_000_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPORT-1:0]   lvl_wr,
    input  logic [2*NPORT-1:0] lvl_req,
    input  logic [NPORT-1:0]   ext_wr,
    input  logic [NPORT-1:0]   ext_val,
    input  logic [NPORT-1:0]   pgood,
    input  logic [NPORT-1:0]   fault_n,
    output logic [NPORT-1:0]   port_en,
    output logic [NPORT-1:0]   sel_2v5,
    output logic [NPORT-1:0]   sel_3v3,
    output logic [NPORT-1:0]   ext_en,
    output logic [NPORT-1:0]   busy,
    output logic [NPORT-1:0]   pg_timeout,
    output logic [2*NPORT-1:0] ext_state
);
    localparam int TMO_CYC = CLK_HZ;

    logic [NPORT-1:0] pg_s;
    logic [NPORT-1:0] flt_s;

    dps_sync #(.W(NPORT), .RST_VAL(1'b0)) u_pg_sync (
        .clk(clk), .rst(rst), .d(pgood), .q(pg_s)
    );

    dps_sync #(.W(NPORT), .RST_VAL(1'b1)) u_flt_sync (
        .clk(clk), .rst(rst), .d(fault_n), .q(flt_s)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rail_t rail;

        dps_seq #(.TMO_CYC(TMO_CYC)) u_seq (
            .clk     (clk),
            .rst     (rst),
            .lvl_wr  (lvl_wr[p]),
            .lvl_req (lvl_req[2*p +: 2]),
            .pg_s    (pg_s[p]),
            .rail    (rail),
            .busy    (busy[p]),
            .tmo     (pg_timeout[p])
        );

        assign port_en[p] = rail.en;
        assign sel_2v5[p] = rail.s25;
        assign sel_3v3[p] = rail.s33;

        dps_extpwr u_ext (
            .clk     (clk),
            .rst     (rst),
            .flt_s   (flt_s[p]),
            .ext_wr  (ext_wr[p]),
            .ext_val (ext_val[p]),
            .ext_en  (ext_en[p]),
            .state   (ext_state[2*p +: 2])
        );
    end
endmodule

// File: tb/sim_dio_power_seq.sv
`timescale 1ns/1ps
module sim_dio_power_seq;
    localparam int PERIOD = 10;
    localparam int NP     = 2;
    localparam int TMO    = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] lvl_wr, ext_wr, ext_val, pgood, fault_n;
    logic [2*NP-1:0] lvl_req;
    logic [NP-1:0] port_en, sel_2v5, sel_3v3, ext_en, busy, pg_timeout;
    logic [2*NP-1:0] ext_state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    dio_power_seq #(.NPORT(NP), .CLK_HZ(TMO)) u0 (
        .clk(clk), .rst(rst), .lvl_wr(lvl_wr), .lvl_req(lvl_req),
        .ext_wr(ext_wr), .ext_val(ext_val), .pgood(pgood), .fault_n(fault_n),
        .port_en(port_en), .sel_2v5(sel_2v5), .sel_3v3(sel_3v3),
        .ext_en(ext_en), .busy(busy), .pg_timeout(pg_timeout),
        .ext_state(ext_state)
    );

    // {port, level[1:0], en, s25, s33}
    localparam logic [5:0] VEC [0:7] = '{
        6'b0_01_100, 6'b0_10_110, 6'b0_11_101, 6'b0_00_000,
        6'b1_10_110, 6'b1_00_000, 6'b1_01_100, 6'b1_11_101
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] tri_of(input int p);
        return {port_en[p], sel_2v5[p], sel_3v3[p]};
    endfunction

    task automatic req_lvl(input int p, input logic [1:0] l);
        lvl_wr[p] = 1'b1;
        lvl_req[2*p +: 2] = l;
        tick();
        lvl_wr = '0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lvl_wr = '0; lvl_req = '0; ext_wr = '0; ext_val = '0;
        pgood = '1; fault_n = '1;
        tick(); tick();
        // R9: reset state
        chk(port_en == 0 && sel_2v5 == 0 && sel_3v3 == 0, "R9 reset enables", {port_en, sel_3v3}, 0);
        chk(ext_en == 0 && ext_state == 0, "R9 reset ext", {ext_en, ext_state}, 0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        chk(tri_of(0) == 3'b101 && tri_of(1) == 3'b101, "R9 up at 3v3", {tri_of(0), tri_of(1)}, 6'b101101);
        chk(busy == 0, "R9 busy done", busy, 0);

        // Table walk: R1, R2, R3, R4
        for (int i = 0; i < 8; i++) begin
            automatic int p = VEC[i][5];
            automatic logic [1:0] l = VEC[i][4:3];
            automatic logic [2:0] e = VEC[i][2:0];
            lvl_wr[p] = 1'b1;
            lvl_req[2*p +: 2] = l;
            tick();
            lvl_wr = '0;
            chk(tri_of(p) == 3'b000 && busy[p], "R2 clear first", tri_of(p), 0);
            tick();
            chk(tri_of(p) == {1'b0, e[1:0]}, "R3 select before enable", tri_of(p), {1'b0, e[1:0]});
            tick();
            if (l != 2'd0) chk(port_en[p] && busy[p], "R4 waiting on pg", {port_en[p], busy[p]}, 2'b11);
            else           chk(!port_en[p] && !busy[p], "R4 off no wait", {port_en[p], busy[p]}, 0);
            tick();
            chk(tri_of(p) == e && !busy[p], "R1 level encoding", tri_of(p), e);
        end

        // R5 timeout on port A, R11 port B untouched
        req_lvl(1, 2'd3);
        for (int i = 0; i < 4; i++) tick();
        pgood[0] = 1'b0;
        tick(); tick();
        req_lvl(0, 2'd3);         // CLEAR after this edge
        tick();                    // SEL
        tick();                    // WAIT entered
        for (int i = 0; i < TMO - 1; i++) tick();
        chk(busy[0] && !pg_timeout[0], "R5 not yet timed out", pg_timeout[0], 0);
        tick();
        chk(pg_timeout[0] && !busy[0], "R5 timeout set", pg_timeout[0], 1);
        chk(tri_of(0) == 3'b101, "R5 level held", tri_of(0), 3'b101);
        chk(tri_of(1) == 3'b101 && !pg_timeout[1], "R11 other port", {tri_of(1), pg_timeout[1]}, 4'b1010);
        tick(); tick();
        chk(pg_timeout[0], "R5 sticky", pg_timeout[0], 1);

        // R10 restart mid-wait
        req_lvl(0, 2'd1);
        chk(!pg_timeout[0], "R5 cleared by write", pg_timeout[0], 0);
        tick(); tick(); tick(); tick();
        chk(busy[0] && port_en[0], "R10 waiting", busy[0], 1);
        req_lvl(0, 2'd2);
        chk(tri_of(0) == 3'b000 && busy[0], "R10 restart clears", tri_of(0), 0);
        for (int i = 0; i < TMO - 3; i++) tick();
        chk(busy[0] && !pg_timeout[0], "R10 fresh count", pg_timeout[0], 0);
        pgood[0] = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        chk(tri_of(0) == 3'b110 && !busy[0] && !pg_timeout[0], "R10 completes", tri_of(0), 3'b110);

        // R7, R8 external power
        ext_wr = 2'b11; ext_val = 2'b11;
        tick();
        ext_wr = '0;
        chk(ext_en == 2'b11 && ext_state == 4'b0101, "R8 on state", ext_state, 4'b0101);

        // R6 fault on port A
        fault_n[0] = 1'b0;
        tick(); tick();
        chk(ext_en[0], "R6 before detection", ext_en[0], 1);
        tick();
        chk(!ext_en[0] && ext_state[1:0] == 2'd2, "R6 fault", ext_state[1:0], 2);
        chk(ext_en[1] && ext_state[3:2] == 2'd1, "R11 port B ext", ext_state[3:2], 1);
        fault_n[0] = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        chk(ext_state[1:0] == 2'd2, "R8 fault sticky", ext_state[1:0], 2);

        // R7 host write clears fault
        ext_wr[0] = 1'b1; ext_val[0] = 1'b0;
        tick();
        ext_wr = '0;
        chk(ext_state[1:0] == 2'd0 && !ext_en[0], "R7 clear to off", ext_state[1:0], 0);
        ext_wr[0] = 1'b1; ext_val[0] = 1'b1;
        tick();
        ext_wr = '0;
        chk(ext_state[1:0] == 2'd1 && ext_en[0], "R7 re-enable", ext_state[1:0], 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule